// File: doc/BRIEF.md
# Pulse period and active-width capture unit

This block measures a pulse train arriving on one of several selectable sense inputs. A prescaled up-counter runs from the core clock. Each active edge of the selected input clears it, so the count held just before that clear is the time since the previous active edge, which is the period. The opposite edge falls inside the cycle and its count is the active width. Two capture slots latch these values. Which slot holds the period and which holds the width depends on the input that is selected. The polarity setting decides whether rising or falling edges are active.

Software programs the unit through a small write-only register port: a command word for start and stop, the configuration (polarity and input select), the prescaler divide value, the counter reload limit, the interrupt enables, and a flag register that is cleared by writing zeros. There are three sticky event flags, one per capture slot and one for counter overflow. An interrupt line is raised while any flag with its enable set is pending. A service code names the source to handle first. A measurement tracker reports a complete period, or a failed one when the counter overflows first. A read port returns either capture slot.

Top module: `pwmcap_top`

## Requirements
- R1: The counter advances once every DIV+1 clock cycles, where DIV is the 16-bit value written to address 2. If P clocks separate two active edges, slot holding the period reads floor((P-1)/(DIV+1)). If W clocks separate an active edge from the following opposite edge, the slot holding the width reads floor((W-1)/(DIV+1)).
- R2: When a counter tick finds the counter equal to the reload limit (address 3), the counter wraps to zero and flag bit 2 (overflow) sets. A written limit of zero acts as the all-ones value of the counter width.
- R3: With configuration bit 0 (address 1) low, rising edges are active. A rising edge stores the count in the period slot and clears counter and prescaler. A falling edge stores the count in the width slot.
- R4: With configuration bit 0 high, falling edges are active and rising edges are the opposite edges. The slot roles from R3 are otherwise unchanged.
- R5: Configuration bit 1 selects the sense input. With input 0 selected, slot 0 holds the period and slot 1 the width. With input 1 selected, slot 0 holds the width and slot 1 the period. rd_sel picks the slot shown on rd_data.
- R6: Writing the command word (address 0) with bit 0 set and bit 1 clear starts a run. This clears counter, prescaler and all flags, then enables counting. Writing bit 1 stops the run. In that same cycle it disables counting and clears all enables and all flags. While stopped, input edges change no capture slot and no flag.
- R7: Flag bit 0 sets when slot 0 captures and flag bit 1 when slot 1 captures. Both are sticky. Writing address 5 clears each flag written as 0 and keeps each flag written as 1. irq is high exactly when some flag with its enable bit (same position, address 4) is set.
- R8: svc_id names the pending enabled source to handle first: 1 for width, 2 for period, 3 for overflow, 0 for none. Width goes before period, and period goes before overflow.
- R9: A nonzero write to address 4 while all enables are zero clears all flags and loads the new enables in one cycle. A nonzero write while any enable is set is ignored. A zero write clears the enables and leaves the flags alone.
- R10: After a start, meas_done sets on the second active edge. meas_fail sets if an overflow occurs before that second edge. Both outputs hold until the next start or stop.
- R11: Each sense input passes through two synchroniser stages. A capture and its flag appear at the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_in | input | NPIN | Asynchronous pulse inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Register write data |
| rd_sel | input | 1 | Capture slot select for rd_data |
| rd_data | output | CW | Selected capture slot |
| flags | output | 3 | Sticky flags: slot 0, slot 1, overflow |
| irq | output | 1 | Enabled-flag interrupt |
| svc_id | output | 2 | Highest-priority pending source |
| meas_done | output | 1 | Full period observed since start |
| meas_fail | output | 1 | Overflow before period completed |

## Verification
The bench uses the default 16-bit counter with two inputs. The all-ones reload case can therefore be reached directly, with an overflow after exactly 65536 ticks. Divide values of 0 and 3 are used. The divide-by-4 runs place edges on both sides of a tick boundary, which exercises the floor rule. A reload limit of 5 forces overflows quickly, so flag priority, enable-write semantics and the failed-measurement path are all reached in a few hundred cycles.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;

    typedef enum logic [2:0] {
        REG_CMD    = 3'd0,
        REG_CFG    = 3'd1,
        REG_DIV    = 3'd2,
        REG_RELOAD = 3'd3,
        REG_IEN    = 3'd4,
        REG_FLAGS  = 3'd5
    } reg_addr_e;

    localparam int NFLAG    = 3;
    localparam int FLAG_S0  = 0;
    localparam int FLAG_S1  = 1;
    localparam int FLAG_OVF = 2;

    typedef enum logic [1:0] {
        SVC_NONE   = 2'd0,
        SVC_WIDTH  = 2'd1,
        SVC_PERIOD = 2'd2,
        SVC_OVF    = 2'd3
    } svc_e;

    typedef enum logic [2:0] {
        MEAS_IDLE = 3'd0,
        MEAS_ARM  = 3'd1,
        MEAS_WAIT = 3'd2,
        MEAS_DONE = 3'd3,
        MEAS_FAIL = 3'd4
    } meas_e;

endpackage

// File: rtl/pwmcap_insync.sv
module pwmcap_insync #(
    parameter int NPIN = 2,
    localparam int SELW = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [SELW-1:0] sel,
    input  logic            act_low,
    output logic            act_edge,
    output logic            opp_edge
);

    typedef struct packed {
        logic [NPIN-1:0] meta;
        logic [NPIN-1:0] stab;
        logic [NPIN-1:0] hist;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  lvl_now, lvl_old, rise, fall;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pins;
        sync_d.stab = sync_q.meta;
        sync_d.hist = sync_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // Select after synchronising: both taps come from one pin, so a change
    // of selection cannot fabricate an edge.
    assign lvl_now  = sync_q.stab[sel];
    assign lvl_old  = sync_q.hist[sel];
    assign rise     = lvl_now & ~lvl_old;
    assign fall     = ~lvl_now & lvl_old;
    assign act_edge = act_low ? fall : rise;
    assign opp_edge = act_low ? rise : fall;

endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter #(
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start,
    input  logic          clr,
    input  logic [DW-1:0] div,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          ovf_evt
);

    typedef struct packed {
        logic [DW-1:0] pre;
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t          cnt_d, cnt_q;
    logic [CW-1:0] limit;

    assign limit = (reload == '0) ? '1 : reload;

    always_comb begin
        cnt_d   = cnt_q;
        ovf_evt = 1'b0;
        if (start) begin
            cnt_d.pre = '0;
            cnt_d.cnt = '0;
        end else if (run) begin
            if (clr) begin
                cnt_d.pre = '0;
                cnt_d.cnt = '0;
            end else if (cnt_q.pre == div) begin
                cnt_d.pre = '0;
                if (cnt_q.cnt == limit) begin
                    cnt_d.cnt = '0;
                    ovf_evt   = 1'b1;
                end else begin
                    cnt_d.cnt = cnt_q.cnt + 1'b1;
                end
            end else begin
                cnt_d.pre = cnt_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

endmodule

// File: rtl/pwmcap_capture.sv
module pwmcap_capture
    import pwmcap_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             stop,
    input  logic             flag_clr,
    input  logic             swap,
    input  logic             act_edge,
    input  logic             opp_edge,
    input  logic [CW-1:0]    count,
    input  logic             ovf_evt,
    input  logic             flag_wr,
    input  logic [NFLAG-1:0] flag_wdata,
    output logic [1:0][CW-1:0] caps,
    output logic [NFLAG-1:0] flags,
    output logic             meas_done,
    output logic             meas_fail
);

    typedef struct packed {
        logic [1:0][CW-1:0] cap;
        logic [NFLAG-1:0]   flags;
        meas_e              meas;
    } cap_t;

    cap_t             cap_d, cap_q;
    logic [1:0]       trig;
    logic [NFLAG-1:0] set;

    // Slot 0 takes the active edge unless the input select swaps roles.
    for (genvar gi = 0; gi < 2; gi++) begin : g_slot
        if (gi == 0) begin : g_first
            assign trig[gi] = swap ? opp_edge : act_edge;
        end else begin : g_second
            assign trig[gi] = swap ? act_edge : opp_edge;
        end
    end

    always_comb begin
        cap_d = cap_q;
        set   = '0;
        for (int i = 0; i < 2; i++) begin
            if (run && trig[i]) begin
                cap_d.cap[i] = count;
                set[i]       = 1'b1;
            end
        end
        set[FLAG_OVF] = run & ovf_evt;
        cap_d.flags   = (flag_wr ? (cap_q.flags & flag_wdata) : cap_q.flags) | set;
        if (start || stop || flag_clr) cap_d.flags = '0;

        case (cap_q.meas)
            MEAS_ARM: begin
                if (run && act_edge)     cap_d.meas = MEAS_WAIT;
                else if (run && ovf_evt) cap_d.meas = MEAS_FAIL;
            end
            MEAS_WAIT: begin
                if (run && act_edge)     cap_d.meas = MEAS_DONE;
                else if (run && ovf_evt) cap_d.meas = MEAS_FAIL;
            end
            default: ;
        endcase
        if (start) cap_d.meas = MEAS_ARM;
        if (stop)  cap_d.meas = MEAS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign caps      = cap_q.cap;
    assign flags     = cap_q.flags;
    assign meas_done = (cap_q.meas == MEAS_DONE);
    assign meas_fail = (cap_q.meas == MEAS_FAIL);

endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top
    import pwmcap_pkg::*;
#(
    parameter int CW   = 16,
    parameter int DW   = 16,
    parameter int NPIN = 2,
    localparam int SELW = $clog2(NPIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  sense_in,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CW-1:0]    reg_wdata,
    input  logic             rd_sel,
    output logic [CW-1:0]    rd_data,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic [1:0]       svc_id,
    output logic             meas_done,
    output logic             meas_fail
);

    typedef struct packed {
        logic             run;
        logic             act_low;
        logic [SELW-1:0]  pin_sel;
        logic [DW-1:0]    div;
        logic [CW-1:0]    reload;
        logic [NFLAG-1:0] ien;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic               start, stop, ien_clr, flag_wr;
    logic               act_edge, opp_edge, ovf_evt, swap;
    logic [CW-1:0]      count;
    logic [1:0][CW-1:0] caps;
    logic [NFLAG-1:0]   pending;
    int                 width_bit, period_bit;

    always_comb begin
        ctl_d   = ctl_q;
        start   = 1'b0;
        stop    = 1'b0;
        ien_clr = 1'b0;
        flag_wr = 1'b0;
        if (reg_we) begin
            case (reg_addr_e'(reg_addr))
                REG_CMD: begin
                    stop  = reg_wdata[1];
                    start = reg_wdata[0] & ~reg_wdata[1];
                end
                REG_CFG: begin
                    ctl_d.act_low = reg_wdata[0];
                    ctl_d.pin_sel = reg_wdata[1 +: SELW];
                end
                REG_DIV:    ctl_d.div    = reg_wdata[DW-1:0];
                REG_RELOAD: ctl_d.reload = reg_wdata;
                REG_IEN: begin
                    if (reg_wdata[NFLAG-1:0] == '0) begin
                        ctl_d.ien = '0;
                    end else if (ctl_q.ien == '0) begin
                        ctl_d.ien = reg_wdata[NFLAG-1:0];
                        ien_clr   = 1'b1;
                    end
                end
                REG_FLAGS: flag_wr = 1'b1;
                default: ;
            endcase
        end
        if (start) ctl_d.run = 1'b1;
        if (stop) begin
            ctl_d.run = 1'b0;
            ctl_d.ien = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign swap = ctl_q.pin_sel[0];

    pwmcap_insync #(.NPIN(NPIN)) u_insync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (sense_in),
        .sel      (ctl_q.pin_sel),
        .act_low  (ctl_q.act_low),
        .act_edge (act_edge),
        .opp_edge (opp_edge)
    );

    pwmcap_counter #(.CW(CW), .DW(DW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.run),
        .start   (start),
        .clr     (act_edge),
        .div     (ctl_q.div),
        .reload  (ctl_q.reload),
        .count   (count),
        .ovf_evt (ovf_evt)
    );

    pwmcap_capture #(.CW(CW)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctl_q.run),
        .start      (start),
        .stop       (stop),
        .flag_clr   (ien_clr),
        .swap       (swap),
        .act_edge   (act_edge),
        .opp_edge   (opp_edge),
        .count      (count),
        .ovf_evt    (ovf_evt),
        .flag_wr    (flag_wr),
        .flag_wdata (reg_wdata[NFLAG-1:0]),
        .caps       (caps),
        .flags      (flags),
        .meas_done  (meas_done),
        .meas_fail  (meas_fail)
    );

    assign pending    = flags & ctl_q.ien;
    assign irq        = |pending;
    assign width_bit  = swap ? FLAG_S0 : FLAG_S1;
    assign period_bit = swap ? FLAG_S1 : FLAG_S0;

    always_comb begin
        if (pending[width_bit])      svc_id = SVC_WIDTH;
        else if (pending[period_bit]) svc_id = SVC_PERIOD;
        else if (pending[FLAG_OVF])  svc_id = SVC_OVF;
        else                         svc_id = SVC_NONE;
    end

    assign rd_data = caps[rd_sel];

endmodule

// File: rtl/pwmcap_checker.sv
module pwmcap_checker
    import pwmcap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [1:0] cmd_bits,
    input logic [2:0] flags,
    input logic       irq,
    input logic [1:0] svc_id,
    input logic       meas_done,
    input logic       meas_fail
);

    logic cmd_wr;
    assign cmd_wr = reg_we && (reg_addr == REG_CMD);

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[1]) |=> (flags == '0 && !irq && svc_id == SVC_NONE && !meas_done && !meas_fail)); // R6

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[0] && !cmd_bits[1]) |=> (flags == '0 && !meas_done && !meas_fail)); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0)); // R7

    AST_SVC_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (svc_id != SVC_NONE)); // R8

    AST_MEAS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_done && meas_fail)); // R10

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !cmd_wr) |=> meas_done); // R10

    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_fail && !cmd_wr) |=> meas_fail); // R10

endmodule

bind pwmcap_top pwmcap_checker u_pwmcap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .cmd_bits  (reg_wdata[1:0]),
    .flags     (flags),
    .irq       (irq),
    .svc_id    (svc_id),
    .meas_done (meas_done),
    .meas_fail (meas_fail)
);

// File: tb/test_pwmcap_top.sv
module test_pwmcap_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sense_in = 2'b00;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic          rd_sel = 1'b0;
    logic [CW-1:0] rd_data;
    logic [2:0]    flags;
    logic          irq;
    logic [1:0]    svc_id;
    logic          meas_done, meas_fail;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwmcap_top #(.CW(CW)) i_pwmcap_top (
        .clk(clk), .rst_n(rst_n), .sense_in(sense_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .flags(flags), .irq(irq), .svc_id(svc_id),
        .meas_done(meas_done), .meas_fail(meas_fail)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_slot(input logic s, output logic [CW-1:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Inactive level, start, then one active edge, W clocks to the opposite
    // edge, P clocks between active edges.
    task automatic measure(input int idx, input bit act_low, input int w, input int p);
        sense_in[idx] = act_low;
        wait_clk(6);
        wr(3'd0, 16'h0001);
        sense_in[idx] = ~act_low;
        wait_clk(w);
        sense_in[idx] = act_low;
        wait_clk(p - w);
        sense_in[idx] = ~act_low;
        wait_clk(6);
    endtask

    task automatic t_reset;
        logic [CW-1:0] v;
        read_slot(1'b0, v);
        chk("R7", "reset flags", 32'(flags), 0);
        chk("R7", "reset irq", 32'(irq), 0);
        chk("R8", "reset svc", 32'(svc_id), 0);
        chk("R10", "reset done", 32'(meas_done), 0);
        chk("R5", "reset slot0", 32'(v), 0);
    endtask

    task automatic t_overflow(input logic [CW-1:0] rl, input int lim);
        wr(3'd2, 16'd0);
        wr(3'd3, rl);
        wr(3'd0, 16'h0001);
        wait_clk(lim);
        chk("R2", "overflow one tick early", 32'(flags[2]), 0);
        wait_clk(1);
        chk("R2", "overflow at limit", 32'(flags[2]), 1);
        wr(3'd0, 16'h0002);
        chk("R6", "stop clears flags", 32'(flags), 0);
    endtask

    task automatic t_basic;
        logic [CW-1:0] v;
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'd0);
        wr(3'd3, 16'd0);
        sense_in[0] = 1'b0;
        wait_clk(6);
        wr(3'd0, 16'h0001);
        sense_in[0] = 1'b1;
        wait_clk(2);
        chk("R11", "no capture after two clocks", 32'(flags[0]), 0);
        wait_clk(1);
        chk("R11", "capture at third clock", 32'(flags[0]), 1);
        wait_clk(4);
        sense_in[0] = 1'b0;
        wait_clk(5);
        sense_in[0] = 1'b1;
        wait_clk(6);
        read_slot(1'b0, v);
        chk("R3", "period slot", 32'(v), 11);
        read_slot(1'b1, v);
        chk("R3", "width slot", 32'(v), 6);
    endtask

    task automatic t_prescale;
        logic [CW-1:0] v;
        wr(3'd2, 16'd3);
        measure(0, 1'b0, 9, 20);
        read_slot(1'b0, v);
        chk("R1", "div4 period P=20", 32'(v), 4);
        read_slot(1'b1, v);
        chk("R1", "div4 width W=9", 32'(v), 2);
        measure(0, 1'b0, 13, 21);
        read_slot(1'b0, v);
        chk("R1", "div4 period P=21", 32'(v), 5);
        read_slot(1'b1, v);
        chk("R1", "div4 width W=13", 32'(v), 3);
        wr(3'd2, 16'd0);
    endtask

    task automatic t_active_low;
        logic [CW-1:0] v;
        wr(3'd1, 16'h0001);
        measure(0, 1'b1, 4, 10);
        read_slot(1'b0, v);
        chk("R4", "active-low period", 32'(v), 9);
        read_slot(1'b1, v);
        chk("R4", "active-low width", 32'(v), 3);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_pin_b;
        logic [CW-1:0] v;
        wr(3'd1, 16'h0002);
        measure(1, 1'b0, 6, 15);
        read_slot(1'b0, v);
        chk("R5", "input1 slot0 holds width", 32'(v), 5);
        read_slot(1'b1, v);
        chk("R5", "input1 slot1 holds period", 32'(v), 14);
    endtask

    task automatic t_stop_ignore;
        logic [CW-1:0] v;
        wr(3'd0, 16'h0002);
        chk("R6", "stop flags", 32'(flags), 0);
        chk("R6", "stop irq", 32'(irq), 0);
        sense_in[1] = 1'b0;
        wait_clk(4);
        sense_in[1] = 1'b1;
        wait_clk(7);
        sense_in[1] = 1'b0;
        wait_clk(5);
        read_slot(1'b0, v);
        chk("R6", "slot0 untouched while stopped", 32'(v), 5);
        read_slot(1'b1, v);
        chk("R6", "slot1 untouched while stopped", 32'(v), 14);
        chk("R6", "no flags while stopped", 32'(flags), 0);
        wr(3'd1, 16'h0000);
    endtask

    task automatic t_irq;
        wr(3'd3, 16'd0);
        measure(0, 1'b0, 3, 8);
        wr(3'd3, 16'd5);
        wait_clk(10);
        chk("R7", "all flags pending", 32'(flags), 7);
        chk("R7", "no irq without enables", 32'(irq), 0);
        wr(3'd4, 16'h0004);
        chk("R9", "first enable clears flags", 32'(flags), 0);
        wait_clk(8);
        chk("R8", "overflow serviced", 32'(svc_id), 3);
        chk("R7", "irq on enabled overflow", 32'(irq), 1);
        wr(3'd4, 16'h0007);
        sense_in[0] = 1'b0;
        wait_clk(4);
        sense_in[0] = 1'b1;
        wait_clk(10);
        chk("R9", "enable write ignored while enabled", 32'(svc_id), 3);
        chk("R9", "pending kept", 32'(flags), 7);
        wr(3'd4, 16'h0000);
        chk("R9", "zero enable drops irq", 32'(irq), 0);
        chk("R9", "zero enable keeps flags", 32'(flags[1:0]), 3);
        wr(3'd4, 16'h0007);
        chk("R9", "re-enable clears flags", 32'(flags), 0);
        sense_in[0] = 1'b0;
        wait_clk(4);
        sense_in[0] = 1'b1;
        wait_clk(10);
        chk("R8", "width first", 32'(svc_id), 1);
        wr(3'd5, 16'h0005);
        chk("R7", "write-one keeps slot0 flag", 32'(flags[0]), 1);
        chk("R8", "period second", 32'(svc_id), 2);
        wr(3'd5, 16'h0004);
        chk("R8", "overflow last", 32'(svc_id), 3);
        wr(3'd0, 16'h0002);
    endtask

    task automatic t_meas;
        wr(3'd3, 16'd0);
        sense_in[0] = 1'b0;
        wait_clk(6);
        wr(3'd0, 16'h0001);
        sense_in[0] = 1'b1;
        wait_clk(6);
        chk("R10", "one edge not complete", 32'(meas_done), 0);
        sense_in[0] = 1'b0;
        wait_clk(3);
        sense_in[0] = 1'b1;
        wait_clk(6);
        chk("R10", "done after second edge", 32'(meas_done), 1);
        chk("R10", "no fail", 32'(meas_fail), 0);
        wr(3'd3, 16'd5);
        wr(3'd0, 16'h0001);
        wait_clk(10);
        chk("R10", "fail with no edge", 32'(meas_fail), 1);
        wr(3'd0, 16'h0001);
        sense_in[0] = 1'b0;
        wait_clk(2);
        sense_in[0] = 1'b1;
        wait_clk(14);
        chk("R10", "fail after arming", 32'(meas_fail), 1);
        chk("R10", "not done after fail", 32'(meas_done), 0);
        wr(3'd0, 16'h0002);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_overflow(16'd5, 5);
        t_overflow(16'd0, 65535);
        t_basic();
        t_prescale();
        t_active_low();
        t_pin_b();
        t_stop_ignore();
        t_irq();
        t_meas();
        finish_run();
    end

endmodule